// File: doc/BRIEF.md
# DTMF Frequency-Counting Tone Decoder

This block turns a pair of squared-up tone signals into a dual-tone digit. One input carries the limited low-group signal and the other the limited high-group signal, both already full-swing logic from external comparators. Each input is brought into the clock domain through a synchronizer. The block then counts reference clock cycles between successive rising edges, so every period yields one count.

Each group keeps a window of its last `AVG_N` period counts. A single period must fall inside a loose window around one of the four nominal frequencies of its group. The sum of the window must fall inside a tight window of about ±2.5 % around that same nominal. The same nominal must also have been seen for `AVG_N` consecutive periods. This combination lets a steady tone with some jitter through and keeps out irregular, voice-like signals. All count bounds are computed at elaboration from the reference clock frequency `CLK_HZ`.

When both groups hold an accepted tone, the early-steering output is raised and the 4-bit digit code is registered. The code keeps its last value while early steering is low.

Top module: `dtmf_count_decoder`

## Requirements
- R1: After reset, `early_steer` is 0 and `digit_code` is 4'b0000.
- R2: The row (low-group) frequencies are 697/770/852/941 Hz and the column (high-group) frequencies are 1209/1336/1477/1633 Hz. Codes are: rows 697–852 with columns 1209–1477 give digits 1–9 as 4'h1–4'h9, row by row. Row 941 gives 4'hB with 1209, 4'hA with 1336 and 4'hC with 1477. Column 1633 gives 4'hD, 4'hE and 4'hF for rows 697, 770 and 852, and 4'h0 for row 941.
- R3: `early_steer` is 1 only while both groups hold an accepted tone; a valid tone in one group alone keeps it 0.
- R4: When either group stops toggling, `early_steer` falls within one longest accepted low-group period plus a few cycles after the last accepted period ends. A period out of range makes it fall within a few cycles of that edge.
- R5: `digit_code` changes only together with `early_steer` being 1, and holds its last value while `early_steer` is 0.
- R6: A steady tone whose period lies within about ±2.5 % of a nominal is accepted.
- R7: Individual periods that deviate by up to about ±3.5 % are tolerated when the average over the window stays within the tight window.
- R8: A tone whose periods each pass the loose check but whose average lies outside the tight window (about +3.5 % period error) is rejected.
- R9: A period that matches no nominal frequency within the loose window (about ±4 %) is never accepted.
- R10: A tone is accepted only after `AVG_N` consecutive periods match the same nominal. One stray period withdraws acceptance, and acceptance returns after `AVG_N` further good periods.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock of frequency `CLK_HZ` |
| rst_n | input | 1 | Asynchronous active-low reset |
| lo_tone_in | input | 1 | Limited low-group tone, asynchronous |
| hi_tone_in | input | 1 | Limited high-group tone, asynchronous |
| early_steer | output | 1 | Both groups hold accepted tones |
| digit_code | output | 4 | Code of the detected digit, held while idle |

## Verification
The hardest situations to reach are those where the loose per-period check and the tight average disagree. In one, every period passes the loose check but the average is off, which must be rejected. In the other, the periods jitter strongly but average to the nominal, which must be accepted. The bench's tone generators therefore alternate between two programmable period lengths and can insert a single stray period into an otherwise steady tone. This exercises the average check, the consecutive-run rule and the withdrawal of acceptance independently of the plain digit table.

// File: rtl/dtmf_dec_pkg.sv
package dtmf_dec_pkg;

    typedef logic [1:0] band_t;

    function automatic int nominal_hz(input bit high_grp, input int k);
        int f;
        case (k)
            0:       f = high_grp ? 1209 : 697;
            1:       f = high_grp ? 1336 : 770;
            2:       f = high_grp ? 1477 : 852;
            default: f = high_grp ? 1633 : 941;
        endcase
        return f;
    endfunction

    // smallest accepted period count for frequency f and tolerance tol (per mille)
    function automatic int count_min(input longint clk_hz, input int f, input int tol);
        longint den;
        den = longint'(f) * longint'(1000 + tol);
        return int'((clk_hz * 1000 + den - 1) / den);
    endfunction

    // largest accepted period count
    function automatic int count_max(input longint clk_hz, input int f, input int tol);
        longint den;
        den = longint'(f) * longint'(1000 - tol);
        return int'((clk_hz * 1000) / den);
    endfunction

    function automatic logic [3:0] key_code(input band_t row, input band_t col);
        logic [3:0] c;
        if (col == 2'd3) begin
            c = 4'd13 + {2'b00, row};
        end else if (row == 2'd3) begin
            case (col)
                2'd0:    c = 4'hB;
                2'd1:    c = 4'hA;
                default: c = 4'hC;
            endcase
        end else begin
            c = 4'(3 * int'(row) + int'(col) + 1);
        end
        return c;
    endfunction

endpackage

// File: rtl/dtmf_period_meter.sv
module dtmf_period_meter #(
    parameter int CNT_W = 10,
    parameter int LIMIT = 600
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tone_in,
    output logic             per_stb,
    output logic [CNT_W-1:0] per_cnt,
    output logic             stale
);

    typedef struct packed {
        logic [2:0]       sync;
        logic [CNT_W-1:0] cnt;
    } meter_t;

    meter_t st_q, st_d;
    logic   rising;

    assign rising = st_q.sync[1] & ~st_q.sync[2];

    always_comb begin
        st_d      = st_q;
        st_d.sync = {st_q.sync[1:0], tone_in};
        if (rising) begin
            st_d.cnt = CNT_W'(1);
        end else if (st_q.cnt != CNT_W'(LIMIT)) begin
            st_d.cnt = st_q.cnt + CNT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.sync <= '0;
            st_q.cnt  <= CNT_W'(LIMIT);
        end else begin
            st_q <= st_d;
        end
    end

    assign per_stb = rising;
    assign per_cnt = st_q.cnt;
    assign stale   = (st_q.cnt == CNT_W'(LIMIT));

    // R4: the period counter saturates at the loss limit
    a_r4_cnt_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        int'(st_q.cnt) <= LIMIT);

    // R4: each detected edge restarts the measurement
    a_r4_edge_restart: assert property (@(posedge clk) disable iff (!rst_n)
        per_stb |=> (st_q.cnt == CNT_W'(1)));

endmodule

// File: rtl/dtmf_band_tracker.sv
module dtmf_band_tracker
    import dtmf_dec_pkg::*;
#(
    parameter longint CLK_HZ    = 1_000_000,
    parameter bit     HIGH_GRP  = 1'b0,
    parameter int     AVG_N     = 4,
    parameter int     CNT_W     = 11,
    parameter int     LOOSE_PPT = 40,
    parameter int     TIGHT_PPT = 25
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             per_stb,
    input  logic [CNT_W-1:0] per_cnt,
    input  logic             stale,
    output logic             tone_ok,
    output band_t            band
);

    localparam int RUN_W = $clog2(AVG_N + 1);
    localparam int SUM_W = CNT_W + $clog2(AVG_N) + 1;

    localparam int LMIN [4] = '{
        count_min(CLK_HZ, nominal_hz(HIGH_GRP, 0), LOOSE_PPT),
        count_min(CLK_HZ, nominal_hz(HIGH_GRP, 1), LOOSE_PPT),
        count_min(CLK_HZ, nominal_hz(HIGH_GRP, 2), LOOSE_PPT),
        count_min(CLK_HZ, nominal_hz(HIGH_GRP, 3), LOOSE_PPT)};
    localparam int LMAX [4] = '{
        count_max(CLK_HZ, nominal_hz(HIGH_GRP, 0), LOOSE_PPT),
        count_max(CLK_HZ, nominal_hz(HIGH_GRP, 1), LOOSE_PPT),
        count_max(CLK_HZ, nominal_hz(HIGH_GRP, 2), LOOSE_PPT),
        count_max(CLK_HZ, nominal_hz(HIGH_GRP, 3), LOOSE_PPT)};
    localparam int TMIN [4] = '{
        count_min(CLK_HZ, nominal_hz(HIGH_GRP, 0), TIGHT_PPT),
        count_min(CLK_HZ, nominal_hz(HIGH_GRP, 1), TIGHT_PPT),
        count_min(CLK_HZ, nominal_hz(HIGH_GRP, 2), TIGHT_PPT),
        count_min(CLK_HZ, nominal_hz(HIGH_GRP, 3), TIGHT_PPT)};
    localparam int TMAX [4] = '{
        count_max(CLK_HZ, nominal_hz(HIGH_GRP, 0), TIGHT_PPT),
        count_max(CLK_HZ, nominal_hz(HIGH_GRP, 1), TIGHT_PPT),
        count_max(CLK_HZ, nominal_hz(HIGH_GRP, 2), TIGHT_PPT),
        count_max(CLK_HZ, nominal_hz(HIGH_GRP, 3), TIGHT_PPT)};

    typedef struct packed {
        logic [AVG_N-1:0][CNT_W-1:0] win;
        logic [RUN_W-1:0]            run;
        band_t                       band;
        logic                        ok;
    } track_t;

    track_t                      st_q, st_d;
    logic                        hit;
    band_t                       hit_idx;
    logic [AVG_N-1:0][CNT_W-1:0] win_sh;
    logic [SUM_W-1:0]            win_sum;
    logic                        sum_in_band;

    always_comb begin
        hit     = 1'b0;
        hit_idx = '0;
        for (int k = 0; k < 4; k++) begin
            if (int'(per_cnt) >= LMIN[k] && int'(per_cnt) <= LMAX[k]) begin
                hit     = 1'b1;
                hit_idx = band_t'(k);
            end
        end

        win_sh[0] = per_cnt;
        for (int i = 1; i < AVG_N; i++) begin
            win_sh[i] = st_q.win[i-1];
        end
        win_sum = '0;
        for (int i = 0; i < AVG_N; i++) begin
            win_sum = win_sum + SUM_W'(win_sh[i]);
        end

        st_d        = st_q;
        sum_in_band = 1'b0;
        if (per_stb) begin
            st_d.win = win_sh;
            if (!hit) begin
                st_d.run = '0;
                st_d.ok  = 1'b0;
            end else begin
                if (st_q.run != '0 && hit_idx == st_q.band) begin
                    if (st_q.run != RUN_W'(AVG_N)) begin
                        st_d.run = st_q.run + RUN_W'(1);
                    end
                end else begin
                    st_d.run  = RUN_W'(1);
                    st_d.band = hit_idx;
                end
                sum_in_band = (int'(win_sum) >= AVG_N * TMIN[st_d.band]) &&
                              (int'(win_sum) <= AVG_N * TMAX[st_d.band]);
                st_d.ok = (st_d.run == RUN_W'(AVG_N)) && sum_in_band;
            end
        end else if (stale) begin
            st_d.run = '0;
            st_d.ok  = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign tone_ok = st_q.ok;
    assign band    = st_q.band;

    // R10: the consecutive-period run never passes its target
    a_r10_run_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        int'(st_q.run) <= AVG_N);

    // R10: acceptance can only begin on a completed period
    a_r10_ok_on_period: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tone_ok) |-> $past(per_stb));

    // R4: a silent input withdraws acceptance
    a_r4_stale_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (stale && !per_stb) |=> !tone_ok);

endmodule

// File: rtl/dtmf_count_decoder.sv
module dtmf_count_decoder
    import dtmf_dec_pkg::*;
#(
    parameter longint CLK_HZ    = 1_000_000,
    parameter int     AVG_N     = 4,
    parameter int     LOOSE_PPT = 40,
    parameter int     TIGHT_PPT = 25
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       lo_tone_in,
    input  logic       hi_tone_in,
    output logic       early_steer,
    output logic [3:0] digit_code
);

    localparam int LIMIT = count_max(CLK_HZ, nominal_hz(1'b0, 0), LOOSE_PPT) + 1;
    localparam int CNT_W = $clog2(LIMIT + 1);

    logic [1:0]             tone_w;
    logic [1:0]             stb_w;
    logic [1:0][CNT_W-1:0]  cnt_w;
    logic [1:0]             stale_w;
    logic [1:0]             ok_w;
    band_t                  band_w [2];

    assign tone_w = {hi_tone_in, lo_tone_in};

    for (genvar g = 0; g < 2; g++) begin : g_grp
        dtmf_period_meter #(
            .CNT_W (CNT_W),
            .LIMIT (LIMIT)
        ) u_meter (
            .clk     (clk),
            .rst_n   (rst_n),
            .tone_in (tone_w[g]),
            .per_stb (stb_w[g]),
            .per_cnt (cnt_w[g]),
            .stale   (stale_w[g])
        );

        dtmf_band_tracker #(
            .CLK_HZ    (CLK_HZ),
            .HIGH_GRP  (g == 1),
            .AVG_N     (AVG_N),
            .CNT_W     (CNT_W),
            .LOOSE_PPT (LOOSE_PPT),
            .TIGHT_PPT (TIGHT_PPT)
        ) u_track (
            .clk     (clk),
            .rst_n   (rst_n),
            .per_stb (stb_w[g]),
            .per_cnt (cnt_w[g]),
            .stale   (stale_w[g]),
            .tone_ok (ok_w[g]),
            .band    (band_w[g])
        );
    end

    typedef struct packed {
        logic       est;
        logic [3:0] code;
    } out_t;

    out_t st_q, st_d;

    always_comb begin
        st_d     = st_q;
        st_d.est = ok_w[0] & ok_w[1];
        if (st_d.est) begin
            st_d.code = key_code(band_w[0], band_w[1]);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign early_steer = st_q.est;
    assign digit_code  = st_q.code;

    // R3: losing either group drops early steering on the next edge
    a_r3_drop_follows_loss: assert property (@(posedge clk) disable iff (!rst_n)
        (early_steer && !(ok_w[0] && ok_w[1])) |=> !early_steer);

    // R5: the code stays put whenever early steering is inactive
    a_r5_code_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !early_steer |-> $stable(digit_code));

endmodule

// File: tb/dtmf_count_decoder_test.sv
module dtmf_count_decoder_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       lo_in = 1'b0;
    logic       hi_in = 1'b0;
    logic       est;
    logic [3:0] code;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    // generator controls: period A/B alternate, 0 means silent
    int  lo_pa = 0, lo_pb = 0, hi_pa = 0, hi_pb = 0;
    bit  lo_spike = 1'b0;

    always #2.5 clk = ~clk;

    dtmf_count_decoder #(.CLK_HZ(200_000), .AVG_N(4)) uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .lo_tone_in  (lo_in),
        .hi_tone_in  (hi_in),
        .early_steer (est),
        .digit_code  (code)
    );

    initial begin : gen_lo
        bit alt = 1'b0;
        forever begin
            if (lo_pa == 0) begin
                lo_in = 1'b0;
                @(negedge clk);
            end else begin
                int p;
                p = alt ? lo_pb : lo_pa;
                if (lo_spike) begin
                    p = 190;
                    lo_spike = 1'b0;
                end
                lo_in = 1'b1;
                repeat (p / 2) @(negedge clk);
                lo_in = 1'b0;
                repeat (p - p / 2) @(negedge clk);
                alt = ~alt;
            end
        end
    end

    initial begin : gen_hi
        bit alt = 1'b0;
        forever begin
            if (hi_pa == 0) begin
                hi_in = 1'b0;
                @(negedge clk);
            end else begin
                int p;
                p = alt ? hi_pb : hi_pa;
                hi_in = 1'b1;
                repeat (p / 2) @(negedge clk);
                hi_in = 1'b0;
                repeat (p - p / 2) @(negedge clk);
                alt = ~alt;
            end
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic set_lo(input int a, input int b);
        lo_pa = a;
        lo_pb = b;
    endtask

    task automatic set_hi(input int a, input int b);
        hi_pa = a;
        hi_pb = b;
    endtask

    task automatic idle();
        set_lo(0, 0);
        set_hi(0, 0);
        repeat (800) @(negedge clk);
    endtask

    // periods in reference clocks at 200 kHz: low, high, expected code (R2)
    localparam int VEC [16][3] = '{
        '{287, 165, 1},  '{287, 150, 2},  '{287, 135, 3},
        '{260, 165, 4},  '{260, 150, 5},  '{260, 135, 6},
        '{235, 165, 7},  '{235, 150, 8},  '{235, 135, 9},
        '{213, 150, 10}, '{213, 165, 11}, '{213, 135, 12},
        '{287, 122, 13}, '{260, 122, 14}, '{235, 122, 15},
        '{213, 122, 0}};

    initial begin : watchdog
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin : main
        repeat (5) @(negedge clk);
        // R1: reset state
        check(est == 1'b0, "R1 est", int'(est), 0);
        check(code == 4'h0, "R1 code", int'(code), 0);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        check(est == 1'b0, "R1 est after release", int'(est), 0);

        // R2 / R5 / R4: digit table
        for (int v = 0; v < 16; v++) begin
            set_lo(VEC[v][0], VEC[v][0]);
            set_hi(VEC[v][1], VEC[v][1]);
            repeat (2500) @(negedge clk);
            check(est == 1'b1, "R2 est for digit", int'(est), 1);
            check(int'(code) == VEC[v][2], "R2 code", int'(code), VEC[v][2]);
            idle();
            check(est == 1'b0, "R4 est after silence", int'(est), 0);
            check(int'(code) == VEC[v][2], "R5 code held", int'(code), VEC[v][2]);
        end

        // R3: low group alone
        set_lo(260, 260);
        repeat (2500) @(negedge clk);
        check(est == 1'b0, "R3 low only", int'(est), 0);
        check(code == 4'h0, "R5 code unchanged by one group", int'(code), 0);
        idle();
        // R3: high group alone
        set_hi(150, 150);
        repeat (2500) @(negedge clk);
        check(est == 1'b0, "R3 high only", int'(est), 0);
        idle();

        // R4: one group stops while the other continues
        set_lo(235, 235);
        set_hi(135, 135);
        repeat (2500) @(negedge clk);
        check(est == 1'b1, "R4 both present", int'(est), 1);
        set_hi(0, 0);
        repeat (600) @(negedge clk);
        check(est == 1'b0, "R4 high lost", int'(est), 0);
        check(code == 4'h9, "R5 code held after loss", int'(code), 9);
        idle();

        // R6: about 2 percent slow low tone
        set_lo(293, 293);
        set_hi(150, 150);
        repeat (2500) @(negedge clk);
        check(est == 1'b1, "R6 offset tone est", int'(est), 1);
        check(code == 4'h2, "R6 offset tone code", int'(code), 2);
        idle();

        // R7: strong jitter with nominal average
        set_lo(297, 277);
        set_hi(165, 165);
        repeat (2500) @(negedge clk);
        check(est == 1'b1, "R7 jitter accepted", int'(est), 1);
        check(code == 4'h1, "R7 jitter code", int'(code), 1);
        idle();

        // R8: each period loosely ok, average too far off
        set_lo(297, 297);
        set_hi(165, 165);
        repeat (2500) @(negedge clk);
        check(est == 1'b0, "R8 biased average rejected", int'(est), 0);
        idle();

        // R9: period between all low nominals
        set_lo(190, 190);
        set_hi(165, 165);
        repeat (2500) @(negedge clk);
        check(est == 1'b0, "R9 out of band rejected", int'(est), 0);
        idle();

        // R10: single stray period withdraws and then restores acceptance
        set_lo(260, 260);
        set_hi(135, 135);
        repeat (2500) @(negedge clk);
        check(est == 1'b1, "R10 before spike", int'(est), 1);
        lo_spike = 1'b1;
        begin
            bit seen_low = 1'b0;
            for (int c = 0; c < 900; c++) begin
                @(negedge clk);
                if (!est) seen_low = 1'b1;
            end
            check(seen_low, "R10 spike drops est", int'(seen_low), 1);
        end
        repeat (2000) @(negedge clk);
        check(est == 1'b1, "R10 recovered", int'(est), 1);
        check(code == 4'h6, "R10 recovered code", int'(code), 6);
        idle();

        // R10: too few periods before silence gives no acceptance
        set_lo(287, 287);
        set_hi(165, 165);
        repeat (700) @(negedge clk);
        check(est == 1'b0, "R10 short burst", int'(est), 0);
        idle();
        check(est == 1'b0, "R10 short burst after idle", int'(est), 0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule